// File: doc/BRIEF.md
# Precise Exception Controller for a Five-Stage Pipeline

This block is the control layer that keeps exceptions precise in an in-order pipeline with the stages fetch, decode, execute, memory and writeback. It owns the fetch program counter and a small register for every stage holding a valid bit, the instruction's address, a 3-bit cause code and the two write controls produced at decode. A fault found at any stage is not acted on where it appears. It is attached to the instruction and carried down with it. The trap happens only when that instruction reaches writeback. In that cycle the address of the faulting instruction and its cause are latched, every younger instruction is discarded, and fetch is redirected to a fixed handler address.

External interrupts enter as an instruction of their own: a no-op already marked with the interrupt cause is placed in the fetch slot, carrying the address that would otherwise have been fetched. It therefore becomes precise like any other fault. A two-state controller allows only one injected interrupt in flight at a time. The datapath, forwarding and the translation buffers are outside this block. Their fault results arrive as plain inputs that refer to whatever instruction currently occupies the matching stage.

Top module: `exc_pipe_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it, `pc_o` equals RESET_PC (0x0100), every stage is empty, `exc_epc` and `exc_cause` read zero, and `exc_take`, `wb_commit` and `mem_wr_en` are low.
- R2: Each cycle with `fetch_en` high and no injection or trap, `pc_o` advances by 4. The instruction fetched at the k-th edge after reset commits at writeback 4 cycles after it enters fetch, with `wb_pc` giving its address. Commits occur in fetch order.
- R3: Cause codes are 1 for interrupt, 2 for fetch-translation fault, 3 for illegal instruction, 4 for overflow and 5 for data-translation fault. Codes 2 and 3 are raised in decode, and code 2 wins when both are raised in the same cycle. Code 4 is raised in execute and code 5 in memory.
- R4: An instruction keeps the first code attached to it. Faults reported for it in later stages do not change that code.
- R5: The oldest faulting instruction is the one trapped. A younger instruction faulting in an earlier cycle does not preempt it.
- R6: `exc_take` is high exactly in the cycle a coded instruction is in writeback. On the next edge `exc_epc` receives its address, `exc_cause` its code, and `pc_o` becomes VEC_PC (0x0080). At all other times `exc_epc` and `exc_cause` hold their values.
- R7: In the trap cycle, all younger instructions are squashed. None of them ever asserts `wb_commit` or `mem_wr_en`, and fetch resumes at VEC_PC.
- R8: An instruction carrying a code never asserts `mem_wr_en` or `wb_commit`. This includes a data-translation fault raised in the same cycle as its memory write.
- R9: When `irq_req` is high and no injected interrupt is in flight, a coded no-op enters fetch with the current `pc_o`, and `pc_o` holds for that edge. While the no-op is in flight, `irq_req` causes no further injection. If an older fault squashes the no-op, a still-pending request is injected again from the handler address.
- R10: `id_mem_we` and `id_reg_we` are sampled while the instruction is in decode. They drive `mem_wr_en` two cycles later and `wb_commit` three cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_en | input | 1 | Fetch one instruction at `pc_o` this cycle |
| irq_req | input | 1 | External interrupt request, level |
| id_itlb_fault | input | 1 | Fetch-translation fault for the decode-stage instruction |
| id_illegal | input | 1 | Illegal encoding for the decode-stage instruction |
| ex_overflow | input | 1 | Arithmetic overflow for the execute-stage instruction |
| mem_dtlb_fault | input | 1 | Data-translation fault for the memory-stage instruction |
| id_reg_we | input | 1 | Decode's register-write control for the decode-stage instruction |
| id_mem_we | input | 1 | Decode's memory-write control for the decode-stage instruction |
| pc_o | output | PC_W | Fetch address |
| wb_commit | output | 1 | Register write of the writeback instruction |
| wb_pc | output | PC_W | Address of the writeback instruction |
| mem_wr_en | output | 1 | Memory write of the memory-stage instruction |
| exc_take | output | 1 | Trap taken this cycle |
| exc_epc | output | PC_W | Address of the trapped instruction |
| exc_cause | output | 3 | Code of the trapped instruction |

## Verification
The hardest situation to reach is the one where faults overlap in time but not in age. One example is a younger instruction faulting in decode one cycle before an older one faults in memory. Another is an injected interrupt that is squashed by an older overflow while the request stays high. The bench reaches these cases by scheduling each fault input to a cycle worked out from the fixed stage offsets: decode at two cycles after the instruction's fetch index, execute at three, memory at four. It sweeps every cause over several instruction positions and then stacks faults on one instruction and across neighbouring ones. The interrupt is held through the squash to observe the re-injection at the handler address.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        EXC_NONE = 3'd0,
        EXC_IRQ  = 3'd1,
        EXC_ITLB = 3'd2,
        EXC_ILL  = 3'd3,
        EXC_OVF  = 3'd4,
        EXC_DTLB = 3'd5
    } exc_code_e;

    typedef enum logic [0:0] {
        IRQ_IDLE     = 1'b0,
        IRQ_INFLIGHT = 1'b1
    } irq_state_e;

    typedef struct packed {
        logic      valid;
        exc_code_e code;
        logic      reg_we;
        logic      mem_we;
    } stage_ctl_t;

endpackage

// File: rtl/exc_detect.sv
module exc_detect
    import exc_pkg::*;
(
    input  logic      id_itlb_fault,
    input  logic      id_illegal,
    input  logic      ex_overflow,
    input  logic      mem_dtlb_fault,
    output exc_code_e id_code,
    output exc_code_e ex_code,
    output exc_code_e mem_code
);

    // Fetch-side translation fault outranks a bad encoding in decode.
    always_comb begin
        if (id_itlb_fault) begin
            id_code = EXC_ITLB;
        end else if (id_illegal) begin
            id_code = EXC_ILL;
        end else begin
            id_code = EXC_NONE;
        end
        ex_code  = ex_overflow    ? EXC_OVF  : EXC_NONE;
        mem_code = mem_dtlb_fault ? EXC_DTLB : EXC_NONE;
    end

endmodule

// File: rtl/exc_stage_reg.sv
module exc_stage_reg
    import exc_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  stage_ctl_t      d_ctl,
    input  logic [PC_W-1:0] d_pc,
    output stage_ctl_t      q_ctl,
    output logic [PC_W-1:0] q_pc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_ctl <= '0;
            q_pc  <= '0;
        end else if (flush) begin
            q_ctl <= '0;
        end else begin
            q_ctl <= d_ctl;
            q_pc  <= d_pc;
        end
    end

endmodule

// File: rtl/exc_irq_fsm.sv
module exc_irq_fsm
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic take,
    output logic inject
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        inject  = 1'b0;
        unique case (state_q)
            IRQ_IDLE: begin
                if (irq_req && !take) begin
                    inject  = 1'b1;
                    state_d = IRQ_INFLIGHT;
                end
            end
            IRQ_INFLIGHT: begin
                if (take) begin
                    state_d = IRQ_IDLE;
                end
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

endmodule

// File: rtl/exc_pipe_ctrl.sv
module exc_pipe_ctrl
    import exc_pkg::*;
#(
    parameter int            PC_W     = 16,
    parameter logic [PC_W-1:0] RESET_PC = 16'h0100,
    parameter logic [PC_W-1:0] VEC_PC   = 16'h0080,
    parameter int            PC_STEP  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_en,
    input  logic            irq_req,
    input  logic            id_itlb_fault,
    input  logic            id_illegal,
    input  logic            ex_overflow,
    input  logic            mem_dtlb_fault,
    input  logic            id_reg_we,
    input  logic            id_mem_we,
    output logic [PC_W-1:0] pc_o,
    output logic            wb_commit,
    output logic [PC_W-1:0] wb_pc,
    output logic            mem_wr_en,
    output logic            exc_take,
    output logic [PC_W-1:0] exc_epc,
    output logic [2:0]      exc_cause
);

    localparam int NSTG   = 5;
    localparam int ST_IF  = 0;
    localparam int ST_ID  = 1;
    localparam int ST_EX  = 2;
    localparam int ST_MEM = 3;
    localparam int ST_WB  = 4;
    localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

    stage_ctl_t      cur_ctl [NSTG];
    stage_ctl_t      nxt_ctl [NSTG];
    logic [PC_W-1:0] cur_pc  [NSTG];
    logic [PC_W-1:0] nxt_pc  [NSTG];
    exc_code_e       det     [NSTG-1];

    exc_code_e       id_code, ex_code, mem_code;
    logic            inject;
    logic            take;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] epc_q;
    exc_code_e       cause_q;

    exc_detect u_detect (
        .id_itlb_fault (id_itlb_fault),
        .id_illegal    (id_illegal),
        .ex_overflow   (ex_overflow),
        .mem_dtlb_fault(mem_dtlb_fault),
        .id_code       (id_code),
        .ex_code       (ex_code),
        .mem_code      (mem_code)
    );

    assign take = cur_ctl[ST_WB].valid && (cur_ctl[ST_WB].code != EXC_NONE);

    exc_irq_fsm u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_req(irq_req),
        .take   (take),
        .inject (inject)
    );

    // Fault detected against the instruction now in each stage.
    always_comb begin
        det[ST_IF]  = EXC_NONE;
        det[ST_ID]  = id_code;
        det[ST_EX]  = ex_code;
        det[ST_MEM] = mem_code;
    end

    // Next contents of every stage: fetch slot plus shifted, code-merged stages.
    always_comb begin
        nxt_ctl[ST_IF].valid  = inject || fetch_en;
        nxt_ctl[ST_IF].code   = inject ? EXC_IRQ : EXC_NONE;
        nxt_ctl[ST_IF].reg_we = 1'b0;
        nxt_ctl[ST_IF].mem_we = 1'b0;
        nxt_pc[ST_IF]         = pc_q;
        for (int i = 1; i < NSTG; i++) begin
            nxt_ctl[i] = cur_ctl[i-1];
            nxt_pc[i]  = cur_pc[i-1];
            if (cur_ctl[i-1].valid && (cur_ctl[i-1].code == EXC_NONE)) begin
                nxt_ctl[i].code = det[i-1];
            end
            if (i == ST_EX) begin
                nxt_ctl[i].reg_we = id_reg_we;
                nxt_ctl[i].mem_we = id_mem_we;
            end
        end
    end

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        exc_stage_reg #(.PC_W(PC_W)) u_reg (
            .clk  (clk),
            .rst_n(rst_n),
            .flush(take),
            .d_ctl(nxt_ctl[g]),
            .d_pc (nxt_pc[g]),
            .q_ctl(cur_ctl[g]),
            .q_pc (cur_pc[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= RESET_PC;
            epc_q   <= '0;
            cause_q <= EXC_NONE;
        end else if (take) begin
            pc_q    <= VEC_PC;
            epc_q   <= cur_pc[ST_WB];
            cause_q <= cur_ctl[ST_WB].code;
        end else if (!inject && fetch_en) begin
            pc_q <= pc_q + STEP;
        end
    end

    assign pc_o      = pc_q;
    assign wb_pc     = cur_pc[ST_WB];
    assign wb_commit = cur_ctl[ST_WB].valid && cur_ctl[ST_WB].reg_we
                       && (cur_ctl[ST_WB].code == EXC_NONE);
    assign mem_wr_en = cur_ctl[ST_MEM].valid && cur_ctl[ST_MEM].mem_we
                       && (nxt_ctl[ST_WB].code == EXC_NONE) && !take;
    assign exc_take  = take;
    assign exc_epc   = epc_q;
    assign exc_cause = cause_q;

endmodule

// File: rtl/exc_pipe_ctrl_chk.sv
module exc_pipe_ctrl_chk #(
    parameter int              PC_W   = 16,
    parameter logic [PC_W-1:0] VEC_PC = 16'h0080
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] pc_o,
    input logic            wb_commit,
    input logic [PC_W-1:0] wb_pc,
    input logic            mem_wr_en,
    input logic            exc_take,
    input logic [PC_W-1:0] exc_epc,
    input logic [2:0]      exc_cause
);

    // R6
    vector_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (pc_o == VEC_PC));

    // R6
    epc_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (exc_epc == $past(wb_pc)));

    // R6
    cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_take |=> ($stable(exc_epc) && $stable(exc_cause)));

    // R3
    cause_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |=> (exc_cause != 3'd0));

    // R7
    squash_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> !mem_wr_en);

    // R8
    fault_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> !wb_commit);

endmodule

bind exc_pipe_ctrl exc_pipe_ctrl_chk #(.PC_W(PC_W), .VEC_PC(VEC_PC)) u_chk (.*);

// File: tb/tb_exc_pipe_ctrl.sv
module tb_exc_pipe_ctrl;

    localparam int RST = 'h100;
    localparam int VEC = 'h080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_en = 1'b0, irq_req = 1'b0;
    logic        id_itlb_fault = 1'b0, id_illegal = 1'b0;
    logic        ex_overflow = 1'b0, mem_dtlb_fault = 1'b0;
    logic        id_reg_we = 1'b0, id_mem_we = 1'b0;
    logic [15:0] pc_o, wb_pc, exc_epc;
    logic        wb_commit, mem_wr_en, exc_take;
    logic [2:0]  exc_cause;

    int n_chk = 0;
    int n_fail = 0;

    logic [39:0] a_itlb, a_ill, a_ovf, a_dtlb, a_irq;

    always #4 clk = ~clk;

    exc_pipe_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .irq_req(irq_req),
        .id_itlb_fault(id_itlb_fault), .id_illegal(id_illegal),
        .ex_overflow(ex_overflow), .mem_dtlb_fault(mem_dtlb_fault),
        .id_reg_we(id_reg_we), .id_mem_we(id_mem_we),
        .pc_o(pc_o), .wb_commit(wb_commit), .wb_pc(wb_pc),
        .mem_wr_en(mem_wr_en), .exc_take(exc_take),
        .exc_epc(exc_epc), .exc_cause(exc_cause)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_stim();
        a_itlb = '0; a_ill = '0; a_ovf = '0; a_dtlb = '0; a_irq = '0;
    endtask

    task automatic drive(input int c);
        id_itlb_fault  = a_itlb[c];
        id_illegal     = a_ill[c];
        ex_overflow    = a_ovf[c];
        mem_dtlb_fault = a_dtlb[c];
        irq_req        = a_irq[c];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fetch_en = 1'b0; drive(0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(pc_o == 16'(RST), "R1 pc", pc_o, RST);
        chk(!exc_take && !wb_commit && !mem_wr_en, "R1 strobes", {exc_take, wb_commit, mem_wr_en}, 0);
        chk(exc_epc == 0 && exc_cause == 0, "R1 epc/cause", exc_epc, 0);
        rst_n = 1'b1; fetch_en = 1'b1; id_reg_we = 1'b1; id_mem_we = 1'b1;
    endtask

    // Cycle c runs between edge c and edge c+1 after reset release.
    task automatic run_case(input int take_c, input int exp_epc, input int exp_cause,
                            input int nret, input int stall_c);
        do_reset();
        for (int c = 1; c <= take_c + 1; c++) begin
            int  pexp;
            bit  ecommit, emw;
            @(posedge clk);
            @(negedge clk);
            drive(c);
            #1;
            chk(exc_take == (c == take_c), "R6 take timing", exc_take, (c == take_c));
            ecommit = (c >= 5) && (c - 5 < nret);
            chk(wb_commit == ecommit, "R7 R10 commit", wb_commit, ecommit);
            if (ecommit) chk(wb_pc == 16'(RST + 4*(c-5)), "R2 commit order", wb_pc, RST + 4*(c-5));
            emw = (c >= 4) && (c - 4 < nret);
            chk(mem_wr_en == emw, "R8 R10 mem write", mem_wr_en, emw);
            if (c <= take_c)
                pexp = RST + 4*(c - ((stall_c > 0 && c > stall_c) ? 1 : 0));
            else
                pexp = VEC;
            chk(pc_o == 16'(pexp), "R2 R9 fetch pc", pc_o, pexp);
            if (c == take_c + 1) begin
                chk(exc_epc == 16'(exp_epc), "R5 R6 epc", exc_epc, exp_epc);
                chk(exc_cause == 3'(exp_cause), "R3 R4 cause", exc_cause, exp_cause);
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R3 R8: every decode/execute/memory cause on instructions 0..4
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < 5; n++) begin
                clear_stim();
                case (k)
                    0: a_itlb[n+2] = 1'b1;
                    1: a_ill[n+2]  = 1'b1;
                    2: a_ovf[n+3]  = 1'b1;
                    default: a_dtlb[n+4] = 1'b1;
                endcase
                run_case(n + 5, RST + 4*n, k + 2, n, 0);
            end
        end

        // R9: interrupt injection at cycle m, held until the trap
        for (int m = 1; m < 5; m++) begin
            clear_stim();
            for (int c = m; c <= m + 5; c++) a_irq[c] = 1'b1;
            if (m == 2) a_ovf[m+3] = 1'b1;   // R4 fault on the no-op keeps code 1
            run_case(m + 5, RST + 4*m, 1, m, m);
        end

        // R5: younger decode fault earlier, older memory fault wins
        clear_stim();
        a_ill[5] = 1'b1; a_dtlb[6] = 1'b1;
        run_case(7, RST + 8, 5, 2, 0);

        // R3: both decode faults together, translation fault wins
        clear_stim();
        a_itlb[3] = 1'b1; a_ill[3] = 1'b1;
        run_case(6, RST + 4, 2, 1, 0);

        // R4: first code sticks through later-stage faults
        clear_stim();
        a_ill[3] = 1'b1; a_ovf[4] = 1'b1; a_dtlb[5] = 1'b1;
        run_case(6, RST + 4, 3, 1, 0);

        // R9 R5: older overflow squashes the in-flight no-op, then re-injection
        clear_stim();
        for (int c = 3; c <= 14; c++) a_irq[c] = 1'b1;
        a_ovf[5] = 1'b1;
        run_case(7, RST + 8, 4, 2, 3);
        for (int c = 9; c <= 14; c++) begin
            @(posedge clk);
            @(negedge clk);
            drive(c);
            #1;
            chk(exc_take == (c == 13), "R9 reinjected take", exc_take, (c == 13));
            chk(!wb_commit, "R7 no commit after squash", wb_commit, 0);
            if (c == 9) chk(pc_o == 16'(VEC), "R9 pc held on inject", pc_o, VEC);
            if (c == 14) begin
                chk(exc_epc == 16'(VEC), "R9 reinjected epc", exc_epc, VEC);
                chk(exc_cause == 3'd1, "R9 reinjected cause", exc_cause, 1);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule